// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit register file and a 32-bit external data bus. For every access it forms two things. For loads it produces the value to write back to a register. For stores it produces the word to place on the bus. It handles single-byte and full-word accesses. A configuration input selects whether byte lanes are numbered from the most significant end (big-endian) or from the least significant end (little-endian).

The two low address bits never reach the bus: the bus address is always word aligned. Inside the block those two bits choose the byte lane for byte loads and set the rotation for word loads. A word load from an unaligned address is not faulted and not split. Instead the bus word is rotated right by eight bits per byte of offset, so the byte that was addressed lands in a known position. A byte store copies the low register byte into all four lanes, and external logic picks the lane it writes.

By default one register stage holds the results. They appear, together with a valid flag, one clock after a request strobe.

Top module: `ldst_lane_align`

## Requirements
- R1: A byte load with big-endian numbering (`big_end`=1) at offset n takes bus bits 8*(3-n)+7 down to 8*(3-n). With little-endian numbering (`big_end`=0) it takes bus bits 8n+7 down to 8n. The offset n is `addr[1:0]`, and `is_word`=0 selects a byte access.
- R2: A byte load places the selected byte in `load_data[7:0]` and drives `load_data[31:8]` to zero.
- R3: A word load (`is_word`=1, `is_store`=0) returns the bus word rotated right by 8*n bits in both endian modes. Offset 0 passes the word through unchanged.
- R4: A byte store (`is_store`=1, `is_word`=0) drives `bus_wdata` with `reg_wdata[7:0]` repeated in all four lanes, for every offset and both endian modes.
- R5: A word store drives `reg_wdata` onto `bus_wdata` unchanged for any offset, so register bit 31 always appears on bus bit 31.
- R6: `bus_addr` equals `addr` with bits 1:0 forced to zero.
- R7: `load_data` is zero for a store, and `bus_wdata` is zero for a load.
- R8: With `REG_OUT`=1, `load_data` and `bus_wdata` update, and `out_valid` is high, exactly one clock after a cycle with `req_valid`=1. After a cycle with `req_valid`=0, `out_valid` is low and both data outputs hold their previous values.
- R9: A synchronous active-high `rst` clears `load_data`, `bus_wdata` and `out_valid` on the next clock edge, even while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; the access inputs are sampled while it is high |
| is_word | input | 1 | 1 = word access, 0 = byte access |
| is_store | input | 1 | 1 = store, 0 = load |
| big_end | input | 1 | 1 = big-endian lane numbering, 0 = little-endian |
| addr | input | 32 | Byte address of the access |
| bus_rdata | input | 32 | Word read from the external bus |
| reg_wdata | input | 32 | Register value to be stored |
| bus_addr | output | 32 | Word-aligned address for the bus |
| load_data | output | 32 | Aligned load result |
| bus_wdata | output | 32 | Word to drive on the bus for a store |
| out_valid | output | 1 | Results valid (one clock after the request) |

## Verification
The main table reads one fixed bus word whose four bytes are all different, so every lane choice and every rotation amount gives a different result. It tries byte loads at all four offsets in both endian modes, which separates a correct lane mapping from a mirrored one or an off-by-one lane. Word loads at every offset separate rotate-right from rotate-left and from a plain shift. Stores with a distinct low register byte show the difference between replication, a pass-through word, and unintended rotation. Directed steps then use sparse bus words with bits set near the word edges to catch lost wrap-around bits. They also check that outputs hold while the strobe is low and that a reset issued alongside a live request clears everything.

// File: rtl/ldst_lane_align.sv
module ldst_lane_align #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              is_word,
  input  logic              is_store,
  input  logic              big_end,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              out_valid
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0]    ofs;
  logic [OFS_W-1:0]    lane;
  logic [7:0]          byte_sel;
  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotated;
  logic [DATA_W-1:0]   ld_next;
  logic [DATA_W-1:0]   wd_next;

  assign ofs      = addr[OFS_W-1:0];
  assign lane     = big_end ? ~ofs : ofs;
  assign byte_sel = bus_rdata[lane*8 +: 8];
  assign doubled  = {bus_rdata, bus_rdata};
  assign rotated  = doubled[ofs*8 +: DATA_W];
  assign bus_addr = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  assign ld_next = is_store ? '0 : (is_word ? rotated : DATA_W'(byte_sel));
  assign wd_next = !is_store ? '0 : (is_word ? reg_wdata : {LANES{reg_wdata[7:0]}});

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          load_data <= '0;
          bus_wdata <= '0;
          out_valid <= 1'b0;
        end else begin
          out_valid <= req_valid;
          if (req_valid) begin
            load_data <= ld_next;
            bus_wdata <= wd_next;
          end
        end
      end

      a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
      a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
      a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(load_data) && $stable(bus_wdata));
      a_r2_byte_zext: assert property (@(posedge clk) disable iff (rst)
        req_valid && !is_word && !is_store |=> load_data[DATA_W-1:8] == '0);
      a_r3_rot_bits: assert property (@(posedge clk) disable iff (rst)
        req_valid && is_word && !is_store |=>
          $countones(load_data) == $countones($past(bus_rdata)));
      a_r5_word_store: assert property (@(posedge clk) disable iff (rst)
        req_valid && is_word && is_store |=> bus_wdata == $past(reg_wdata));
      a_r4_byte_rep: assert property (@(posedge clk) disable iff (rst)
        req_valid && !is_word && is_store |=>
          bus_wdata == {LANES{$past(reg_wdata[7:0])}});
      a_r7_load_quiet: assert property (@(posedge clk) disable iff (rst)
        req_valid && !is_store |=> bus_wdata == '0);
      a_r9_reset: assert property (@(posedge clk)
        rst |=> !out_valid && load_data == '0 && bus_wdata == '0);
    end else begin : g_comb
      assign load_data = ld_next;
      assign bus_wdata = wd_next;
      assign out_valid = req_valid;
    end
  endgenerate

endmodule

// File: tb/ldst_lane_align_test.sv
module ldst_lane_align_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        is_word = 1'b0;
  logic        is_store = 1'b0;
  logic        big_end = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] bus_rdata = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] bus_addr;
  logic [31:0] load_data;
  logic [31:0] bus_wdata;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ldst_lane_align uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .is_word(is_word),
    .is_store(is_store), .big_end(big_end), .addr(addr),
    .bus_rdata(bus_rdata), .reg_wdata(reg_wdata), .bus_addr(bus_addr),
    .load_data(load_data), .bus_wdata(bus_wdata), .out_valid(out_valid)
  );

  // {big_end, is_word, is_store, ofs[1:0], rdata, wdata, exp_load, exp_wdata}
  localparam int NV = 18;
  localparam logic [132:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 2'd0, 32'hA1B2C3D4, 32'h112233E5, 32'h000000A1, 32'h0},
    {1'b1, 1'b0, 1'b0, 2'd1, 32'hA1B2C3D4, 32'h112233E5, 32'h000000B2, 32'h0},
    {1'b1, 1'b0, 1'b0, 2'd2, 32'hA1B2C3D4, 32'h112233E5, 32'h000000C3, 32'h0},
    {1'b1, 1'b0, 1'b0, 2'd3, 32'hA1B2C3D4, 32'h112233E5, 32'h000000D4, 32'h0},
    {1'b0, 1'b0, 1'b0, 2'd0, 32'hA1B2C3D4, 32'h112233E5, 32'h000000D4, 32'h0},
    {1'b0, 1'b0, 1'b0, 2'd1, 32'hA1B2C3D4, 32'h112233E5, 32'h000000C3, 32'h0},
    {1'b0, 1'b0, 1'b0, 2'd2, 32'hA1B2C3D4, 32'h112233E5, 32'h000000B2, 32'h0},
    {1'b0, 1'b0, 1'b0, 2'd3, 32'hA1B2C3D4, 32'h112233E5, 32'h000000A1, 32'h0},
    {1'b1, 1'b1, 1'b0, 2'd0, 32'hA1B2C3D4, 32'h112233E5, 32'hA1B2C3D4, 32'h0},
    {1'b1, 1'b1, 1'b0, 2'd1, 32'hA1B2C3D4, 32'h112233E5, 32'hD4A1B2C3, 32'h0},
    {1'b1, 1'b1, 1'b0, 2'd2, 32'hA1B2C3D4, 32'h112233E5, 32'hC3D4A1B2, 32'h0},
    {1'b1, 1'b1, 1'b0, 2'd3, 32'hA1B2C3D4, 32'h112233E5, 32'hB2C3D4A1, 32'h0},
    {1'b0, 1'b1, 1'b0, 2'd1, 32'hA1B2C3D4, 32'h112233E5, 32'hD4A1B2C3, 32'h0},
    {1'b0, 1'b1, 1'b0, 2'd2, 32'hA1B2C3D4, 32'h112233E5, 32'hC3D4A1B2, 32'h0},
    {1'b1, 1'b0, 1'b1, 2'd3, 32'hA1B2C3D4, 32'h112233E5, 32'h0,        32'hE5E5E5E5},
    {1'b0, 1'b0, 1'b1, 2'd1, 32'hA1B2C3D4, 32'h112233E5, 32'h0,        32'hE5E5E5E5},
    {1'b1, 1'b1, 1'b1, 2'd2, 32'hA1B2C3D4, 32'h112233E5, 32'h0,        32'h112233E5},
    {1'b0, 1'b1, 1'b1, 2'd3, 32'hA1B2C3D4, 32'h112233E5, 32'h0,        32'h112233E5}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit be, input bit wd, input bit st, input logic [31:0] a,
                       input logic [31:0] rd, input logic [31:0] wr);
    @(negedge clk);
    big_end = be; is_word = wd; is_store = st; addr = a;
    bus_rdata = rd; reg_wdata = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9 valid after reset", 32'(out_valid), 32'h0);
    chk(load_data == 32'h0, "R9 load after reset", load_data, 32'h0);
    chk(bus_wdata == 32'h0, "R9 wdata after reset", bus_wdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [132:0] v;
      string ltag, wtag;
      v = VEC[i];
      ltag = v[132] ? "" : "";
      if (v[130]) begin
        ltag = "R7 load zero on store";
        wtag = v[131] ? "R5 word store" : "R4 byte store";
      end else begin
        ltag = v[131] ? "R3 word load rotate" : "R1 byte load lane";
        wtag = "R7 wdata zero on load";
      end
      issue(v[132], v[131], v[130], 32'h10000040 | 32'(v[129:128]), v[127:96], v[95:64]);
      chk(bus_addr == 32'h10000040, "R6 aligned bus address", bus_addr, 32'h10000040);
      chk(out_valid == 1'b1, "R8 valid one clock after request", 32'(out_valid), 32'h1);
      chk(load_data == v[63:32], ltag, load_data, v[63:32]);
      chk(bus_wdata == v[31:0], wtag, bus_wdata, v[31:0]);
      if (!v[131] && !v[130])
        chk(load_data[31:8] == 24'h0, "R2 byte load upper zero", load_data, v[63:32]);
    end

    // R3: wrap-around bits with a sparse word
    issue(1'b1, 1'b1, 1'b0, 32'h00000201, 32'h80000001, 32'h0);
    chk(load_data == 32'h01800000, "R3 wrap offset 1", load_data, 32'h01800000);
    issue(1'b0, 1'b1, 1'b0, 32'h00000203, 32'h80000001, 32'h0);
    chk(load_data == 32'h00000180, "R3 wrap offset 3", load_data, 32'h00000180);
    // R1/R2: top lane, little-endian offset 3
    issue(1'b0, 1'b0, 1'b0, 32'h00000003, 32'hFF000000, 32'h0);
    chk(load_data == 32'h000000FF, "R1 LE offset 3 top lane", load_data, 32'h000000FF);
    // R6: all-ones address
    @(negedge clk);
    addr = 32'hFFFFFFFF;
    #1;
    chk(bus_addr == 32'hFFFFFFFC, "R6 low bits cleared", bus_addr, 32'hFFFFFFFC);

    // R8: hold while strobe low
    issue(1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 32'hCAFE0123);
    @(negedge clk);
    is_store = 1'b1; is_word = 1'b0; reg_wdata = 32'h00000077;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid low without request", 32'(out_valid), 32'h0);
    chk(bus_wdata == 32'hCAFE0123, "R8 wdata held", bus_wdata, 32'hCAFE0123);

    // R9: reset during a live request
    issue(1'b0, 1'b1, 1'b0, 32'h0, 32'h12345678, 32'h0);
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; is_store = 1'b1; reg_wdata = 32'h55555555;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid cleared", 32'(out_valid), 32'h0);
    chk(load_data == 32'h0, "R9 load cleared", load_data, 32'h0);
    chk(bus_wdata == 32'h0, "R9 wdata cleared", bus_wdata, 32'h0);
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule